// File: doc/BRIEF.md
# Superchannel Transmit FIFO Aggregator

This block takes one logical transmit byte stream and spreads it across a group of small per-channel member FIFOs. It then drains those FIFOs onto a serial TDM line according to a programmable timeslot routing table. A single parameter context and a single byte source serve the whole group. Each table entry marked as superchannel maps one 8-bit timeslot to one member FIFO. A run of such entries therefore carries consecutive bytes of the stream in consecutive timeslots, which one ordinary channel is not allowed to do.

Each routing entry holds a channel number, a superchannel flag, a slot length code and an end-of-table marker. Source bytes are distributed over the superchannel entries in table order. Each member FIFO that takes part in the superchannel is limited to half its normal depth. Timeslots that are not marked as superchannel belong to ordinary channels, whose data comes from elsewhere, so this block keeps the line at ones during them. A combinational check flags routing tables that break the channel-reservation or adjacency rules.

Top module: `sc_tx_aggregator`

## Requirements
- R1: After reset, `tx_bit` is 1, `underrun` is 0 and `src_ready` is 0. Reset leaves a default table in which entry i is an ordinary 8-bit slot for channel i mod 4, and only the final entry carries the end marker. `cfg_err` is 0 for that table.
- R2: A table write stores `tbl_ch`, `tbl_sc`, `tbl_len` (slot length minus one) and `tbl_last` at `tbl_addr`. Every write restarts the fill pointer at entry 0.
- R3: A source byte is accepted on a clock edge where `src_valid` and `src_ready` are both high. Accepted bytes go to the channels of the superchannel entries, visited in table order and wrapping after the end-marked entry.
- R4: A member FIFO used by any superchannel entry holds at most 2 bytes. `src_ready` is low while the FIFO of the current fill target is full.
- R5: With `bclk_en` high, `fsync` starts entry 0 at the next edge, and each further `bclk_en` edge advances one bit. Bytes leave MSB first, and `tx_bit` shows a bit from the edge that starts it. Before the first `fsync` the line stays at 1.
- R6: A superchannel slot always lasts 8 bits, whatever its length code holds.
- R7: An ordinary slot lasts length code plus one bits and carries ones.
- R8: After the end-marked entry the drain continues at entry 0 without a new `fsync`.
- R9: If a superchannel slot starts while its member FIFO is empty, the slot carries 8'hFF and `underrun` goes high and stays high until reset.
- R10: `cfg_err` is high when one channel appears in both a superchannel entry and an ordinary entry.
- R11: `cfg_err` is high when two entries that follow each other on the line name the same channel. This includes the end-marked entry followed by entry 0.
- R12: Entries placed after the end-marked entry take no part in the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Routing table write strobe |
| tbl_addr | input | 4 | Entry index to write |
| tbl_ch | input | 2 | Channel number of the entry |
| tbl_sc | input | 1 | Entry is a superchannel slot |
| tbl_len | input | 3 | Slot length minus one (ordinary slots) |
| tbl_last | input | 1 | Entry ends the table |
| src_data | input | 8 | Source byte |
| src_valid | input | 1 | Source byte present |
| src_ready | output | 1 | Byte will be taken this edge |
| fsync | input | 1 | Frame sync, aligned to entry 0 |
| bclk_en | input | 1 | Bit clock enable |
| tx_bit | output | 1 | Serial transmit bit |
| underrun | output | 1 | Sticky empty-member flag |
| cfg_err | output | 1 | Routing table breaks a channel rule |

## Verification
`cfg_err` is combinational on the table registers, so it is due one edge after the last write and is sampled on the following falling edge. A byte offered while `src_ready` is high at a falling edge is taken on the next rising edge, and the bench advances its count only at the falling edge after that. The first line bit appears at the falling edge after the rising edge that saw `fsync`. Every later bit is read on each successive falling edge without any gap, so slot boundaries are counted rather than guessed. The `underrun` flag is checked only after enough whole frames for every buffered byte to have drained.

// File: rtl/sc_pkg.sv
// Shared types for the superchannel transmit aggregator.
// Assumes a 4-channel group; the channel field width sets the group size.
package sc_pkg;
    localparam int SC_CH_W  = 2;
    localparam int SC_LEN_W = 3;

    typedef struct packed {
        logic [SC_CH_W-1:0]  ch;    // member / channel number
        logic                sc;    // superchannel slot
        logic [SC_LEN_W-1:0] len;   // slot bits minus one (ordinary slots)
        logic                last;  // end of table
    } sc_entry_t;
endpackage

// File: rtl/sc_route_table.sv
// Routing table storage plus the channel-rule check.
// Assumes entries after the first end-marked one are never reached on the line.
module sc_route_table
    import sc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  sc_entry_t        wdata,
    output sc_entry_t        ent_o [DEPTH],
    output logic [NUM_CH-1:0] sc_member,
    output logic             cfg_err
);
    sc_entry_t         tbl [DEPTH];
    logic [DEPTH-1:0]  act;
    logic [NUM_CH-1:0] in_norm;
    logic              adj_err;

    // Table registers: reset to a rule-clean ordinary table, then host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i].ch   <= SC_CH_W'(i % NUM_CH);
                tbl[i].sc   <= 1'b0;
                tbl[i].len  <= '1;
                tbl[i].last <= (i == DEPTH - 1);
            end
        end else if (we) begin
            tbl[waddr] <= wdata;
        end
    end

    // Active mask and per-channel usage over the reachable entries.
    always_comb begin
        logic alive;
        alive     = 1'b1;
        sc_member = '0;
        in_norm   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            act[i] = alive;
            if (alive) begin
                if (tbl[i].sc) sc_member[tbl[i].ch] = 1'b1;
                else           in_norm[tbl[i].ch]   = 1'b1;
            end
            if (tbl[i].last) alive = 1'b0;
        end
    end

    // Adjacency check, including the wrap from the end entry to entry 0.
    always_comb begin
        adj_err = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [IDX_W-1:0] j;
            j = (tbl[i].last || i == DEPTH - 1) ? '0 : IDX_W'(i + 1);
            if (act[i] && tbl[j].ch == tbl[i].ch) adj_err = 1'b1;
        end
    end

    assign cfg_err = adj_err | (|(sc_member & in_norm));

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign ent_o[g] = tbl[g];
    end
endmodule

// File: rtl/sc_member_fifo.sv
// One member byte FIFO. Full depth in ordinary mode, half depth when the
// channel belongs to the superchannel. Pushes when full and pops when empty
// are dropped; callers are expected never to issue them.
module sc_member_fifo #(
    parameter int FULL_DEPTH = 4,
    localparam int HALF  = FULL_DEPTH / 2,
    localparam int PTR_W = $clog2(FULL_DEPTH),
    localparam int CNT_W = $clog2(FULL_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sc_mode,
    input  logic       push,
    input  logic [7:0] din,
    input  logic       pop,
    output logic [7:0] dout,
    output logic       empty,
    output logic       full
);
    logic [7:0]       mem [FULL_DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt, cap;
    logic             do_push, do_pop;

    assign cap     = sc_mode ? CNT_W'(HALF) : CNT_W'(FULL_DEPTH);
    assign full    = cnt >= cap;
    assign empty   = cnt == '0;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/sc_slot_drain.sv
// Walks the routing table on the bit clock and shifts slot bytes out MSB first.
// Assumes fsync is only acted on together with bclk_en. Ordinary slots are
// driven high; a superchannel slot with an empty member sends ones and sets
// the sticky underrun flag.
module sc_slot_drain
    import sc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NUM_CH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fsync,
    input  logic                   bclk_en,
    input  sc_entry_t              ent [DEPTH],
    input  logic [NUM_CH-1:0]      fifo_empty,
    input  logic [NUM_CH-1:0][7:0] fifo_dout,
    output logic [NUM_CH-1:0]      pop,
    output logic                   tx_bit,
    output logic                   underrun
);
    logic             synced, und;
    logic [IDX_W-1:0] idx, nidx;
    logic [2:0]       bitc;
    logic [7:0]       sh;
    logic             slot_end, start;
    sc_entry_t        cur, nxt;

    assign cur      = ent[idx];
    assign slot_end = bitc == (cur.sc ? 3'd7 : cur.len);
    assign start    = bclk_en && (fsync || (synced && slot_end));
    assign nidx     = (fsync || cur.last || idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;
    assign nxt      = ent[nidx];

    // Pop the member FIFO of a superchannel slot as it starts.
    always_comb begin
        pop = '0;
        if (start && nxt.sc && !fifo_empty[nxt.ch]) pop[nxt.ch] = 1'b1;
    end

    // Slot sequencing, shift register and sticky underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced <= 1'b0;
            idx    <= '0;
            bitc   <= '0;
            sh     <= 8'hFF;
            und    <= 1'b0;
        end else if (start) begin
            synced <= 1'b1;
            idx    <= nidx;
            bitc   <= '0;
            if (nxt.sc && !fifo_empty[nxt.ch]) begin
                sh <= fifo_dout[nxt.ch];
            end else begin
                sh <= 8'hFF;
                if (nxt.sc) und <= 1'b1;
            end
        end else if (bclk_en && synced) begin
            bitc <= bitc + 1'b1;
            sh   <= {sh[6:0], 1'b1};
        end
    end

    assign tx_bit   = sh[7];
    assign underrun = und;

    p_idle_before_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> tx_bit);
    p_sticky_underrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(und) |-> und);
endmodule

// File: rtl/sc_tx_aggregator.sv
// Top: one byte source feeding the superchannel member FIFOs in table order,
// drained onto the TDM line by the slot walker. Assumes the table is written
// while the source is idle; each write restarts the fill pointer at entry 0.
module sc_tx_aggregator
    import sc_pkg::*;
#(
    parameter int TBL_DEPTH  = 16,
    parameter int FIFO_DEPTH = 4,
    localparam int NUM_CH = 2 ** SC_CH_W,
    localparam int IDX_W  = $clog2(TBL_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_addr,
    input  logic [SC_CH_W-1:0] tbl_ch,
    input  logic               tbl_sc,
    input  logic [2:0]         tbl_len,
    input  logic               tbl_last,
    input  logic [7:0]         src_data,
    input  logic               src_valid,
    output logic               src_ready,
    input  logic               fsync,
    input  logic               bclk_en,
    output logic               tx_bit,
    output logic               underrun,
    output logic               cfg_err
);
    sc_entry_t                ent [TBL_DEPTH];
    sc_entry_t                wentry, tgt;
    logic [NUM_CH-1:0]        sc_member, push, pop, f_empty, f_full;
    logic [NUM_CH-1:0][7:0]   f_dout;
    logic [IDX_W-1:0]         fill_idx;
    logic                     take;

    assign wentry = '{ch: tbl_ch, sc: tbl_sc, len: tbl_len, last: tbl_last};

    sc_route_table #(.DEPTH(TBL_DEPTH), .NUM_CH(NUM_CH)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wdata(wentry),
        .ent_o(ent), .sc_member(sc_member), .cfg_err(cfg_err)
    );

    assign tgt       = ent[fill_idx];
    assign src_ready = tgt.sc && !f_full[tgt.ch];
    assign take      = src_valid && src_ready;

    // Route an accepted byte to the current fill target.
    always_comb begin
        push = '0;
        if (take) push[tgt.ch] = 1'b1;
    end

    // Fill pointer: skip ordinary entries, advance past a superchannel entry on accept.
    always_ff @(posedge clk) begin
        if (!rst_n || tbl_we) begin
            fill_idx <= '0;
        end else if (!tgt.sc || take) begin
            fill_idx <= (tgt.last || fill_idx == IDX_W'(TBL_DEPTH - 1)) ? '0 : fill_idx + 1'b1;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mem
        sc_member_fifo #(.FULL_DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .sc_mode(sc_member[c]),
            .push(push[c]), .din(src_data), .pop(pop[c]),
            .dout(f_dout[c]), .empty(f_empty[c]), .full(f_full[c])
        );
    end

    sc_slot_drain #(.DEPTH(TBL_DEPTH), .NUM_CH(NUM_CH)) u_drain (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .bclk_en(bclk_en), .ent(ent),
        .fifo_empty(f_empty), .fifo_dout(f_dout), .pop(pop),
        .tx_bit(tx_bit), .underrun(underrun)
    );

    p_fill_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && !src_ready && tgt.sc && !tbl_we) |=> fill_idx == $past(fill_idx));
endmodule

// File: tb/sc_tx_aggregator_test.sv
`timescale 1ns/1ps
module sc_tx_aggregator_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       tbl_we = 0;
    logic [3:0] tbl_addr = 0;
    logic [1:0] tbl_ch = 0;
    logic       tbl_sc = 0;
    logic [2:0] tbl_len = 0;
    logic       tbl_last = 0;
    logic [7:0] src_data = 8'h10;
    logic       src_valid = 0;
    logic       src_ready;
    logic       fsync = 0;
    logic       bclk_en = 1;
    logic       tx_bit, underrun, cfg_err;

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    bit feed_on = 0;
    bit hs_prev = 0;

    always #2 clk = ~clk;

    sc_tx_aggregator uut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_ch(tbl_ch), .tbl_sc(tbl_sc), .tbl_len(tbl_len), .tbl_last(tbl_last),
        .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
        .fsync(fsync), .bclk_en(bclk_en), .tx_bit(tx_bit),
        .underrun(underrun), .cfg_err(cfg_err)
    );

    // Entry code {ch[1:0], sc, len[2:0], last}; vector = 4 entries, expected cfg_err, requirement.
    localparam logic [32:0] CFG_VEC [0:6] = '{
        {7'b01_1_001_0, 7'b10_1_001_0, 7'b00_0_011_0, 7'b11_1_001_1, 1'b0, 4'd10}, // R10 clean
        {7'b01_1_000_0, 7'b01_1_000_0, 7'b00_0_011_0, 7'b11_1_000_1, 1'b1, 4'd11}, // R11 sc pair
        {7'b01_1_000_0, 7'b10_1_000_0, 7'b01_0_011_0, 7'b11_1_000_1, 1'b1, 4'd10}, // R10 shared ch
        {7'b00_0_111_0, 7'b00_0_111_0, 7'b01_1_000_0, 7'b10_1_000_1, 1'b1, 4'd11}, // R11 ordinary pair
        {7'b11_1_000_0, 7'b00_0_111_0, 7'b01_0_111_0, 7'b11_1_000_1, 1'b1, 4'd11}, // R11 wrap
        {7'b00_1_000_0, 7'b01_1_000_1, 7'b01_0_111_0, 7'b00_0_111_0, 1'b0, 4'd12}, // R12 after end
        {7'b00_1_000_0, 7'b01_1_000_0, 7'b10_1_000_0, 7'b11_1_000_1, 1'b0, 4'd10}  // R10 all members
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [27:0] ents);
        for (int e = 0; e < 4; e++) begin
            @(negedge clk);
            {tbl_ch, tbl_sc, tbl_len, tbl_last} = ents[27 - 7*e -: 7];
            tbl_addr = 4'(e);
            tbl_we   = 1;
        end
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic read_slot(input int len, output logic [7:0] v);
        v = 8'h00;
        for (int b = 0; b < len; b++) begin
            @(negedge clk);
            fsync = 0;
            v = {v[6:0], tx_bit};
        end
    endtask

    // Reads one frame of the clean table: 8, 8, 4, 8 bits.
    task automatic read_frame(output logic [7:0] s0, s1, s2, s3);
        read_slot(8, s0);
        read_slot(8, s1);
        read_slot(4, s2);
        read_slot(8, s3);
    endtask

    // Source driver: counting bytes, advanced after each accepted handshake.
    initial begin
        forever begin
            @(negedge clk);
            if (hs_prev) begin
                pushed++;
                src_data = src_data + 8'd1;
            end
            src_valid = feed_on;
            hs_prev   = src_valid && src_ready;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s0, s1, s2, s3;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(tx_bit == 1'b1,    "R1 tx_bit", tx_bit, 1);
        check(underrun == 1'b0,  "R1 underrun", underrun, 0);
        check(src_ready == 1'b0, "R1 src_ready", src_ready, 0);
        check(cfg_err == 1'b0,   "R1 cfg_err", cfg_err, 0);

        // Configuration rule vectors (R10, R11, R12).
        foreach (CFG_VEC[k]) begin
            write_cfg(CFG_VEC[k][32:5]);
            check(cfg_err == CFG_VEC[k][4],
                  $sformatf("R%0d cfg vector %0d", CFG_VEC[k][3:0], k),
                  cfg_err, CFG_VEC[k][4]);
        end

        // Clean table: ch1 sc, ch2 sc, ch0 ordinary 4 bits, ch3 sc end (R2, R6 length code ignored).
        write_cfg(CFG_VEC[0][32:5]);
        feed_on = 1;
        repeat (20) @(negedge clk);
        check(pushed == 6, "R4 bytes held before drain", pushed, 6);
        check(tx_bit == 1'b1, "R5 idle before sync", tx_bit, 1);

        fsync = 1;
        for (int f = 0; f < 3; f++) begin
            read_frame(s0, s1, s2, s3);
            check(s0 == 8'(8'h10 + 3*f),     $sformatf("R3 R5 R8 frame %0d slot0", f), s0, 8'(8'h10 + 3*f));
            check(s1 == 8'(8'h11 + 3*f),     $sformatf("R6 R8 frame %0d slot1", f), s1, 8'(8'h11 + 3*f));
            check(s2 == 8'h0F,               $sformatf("R7 frame %0d ordinary", f), s2, 8'h0F);
            check(s3 == 8'(8'h12 + 3*f),     $sformatf("R3 R8 frame %0d slot3", f), s3, 8'(8'h12 + 3*f));
        end
        check(underrun == 1'b0, "R9 no underrun while fed", underrun, 0);

        // Starve the source until every member drains.
        feed_on = 0;
        for (int f = 0; f < 4; f++) read_frame(s0, s1, s2, s3);
        check(underrun == 1'b1, "R9 underrun set", underrun, 1);
        read_frame(s0, s1, s2, s3);
        check(s0 == 8'hFF, "R9 empty slot0", s0, 8'hFF);
        check(s1 == 8'hFF, "R9 empty slot1", s1, 8'hFF);
        check(s3 == 8'hFF, "R9 empty slot3", s3, 8'hFF);
        check(underrun == 1'b1, "R9 underrun sticky", underrun, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule